// File: doc/BRIEF.md
# Leveled Peripheral Interrupt Controller

This block gathers event pulses from a group of peripherals and turns them into a single interrupt request for a processor. Each source keeps a pending flag that software clears explicitly. It also has an enable bit and a two-bit urgency level, and the block always presents the most urgent source that is both pending and enabled. That source's level is compared with the level of the code the processor is currently running. A global interrupt-enable input then gates the result, and the request goes out with the winning source index and its level.

When the processor acknowledges a request, it pulses the acknowledge input with the accepted source index. The block then makes that source's level the running level and stacks the previous one. A return strobe brings the stacked level back, so only strictly more urgent sources can nest inside a handler.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every source has enable 0 and level code 3, no flag is pending, `cur_level` is 3, the level stack is empty, and `irq_req` stays 0 even when every source then receives an event.
- R2: A 1 on `src_event[i]` sets pending flag i at the clock edge. The flag stays set until a clear of index i. When an event and a clear of the same index fall in one cycle, the flag stays set.
- R3: A pending source takes part in arbitration only while its enable bit, written through `cfg_we`/`cfg_idx`/`cfg_en`, is 1.
- R4: Level codes rank 1 as most urgent, then 2. Code 0 ranks equal to 1 and is reported on `irq_level` as 1. Code 3 masks the source completely.
- R5: Among the eligible sources, the one with the lowest effective level is presented on `irq_idx`/`irq_level`. Sources with equal levels resolve to the lowest index.
- R6: `irq_req` is 1 only when the winner's effective level is numerically lower than `cur_level`.
- R7: `irq_req` is 0 whenever `gie` is 0.
- R8: On `ack_valid`, `cur_level` becomes the effective level configured for source `ack_idx` and the old level is pushed. A configuration write to that source in the same cycle does not affect this update. If `ret_strobe` falls in the same cycle, it is ignored.
- R9: On `ret_strobe` without an acknowledge, `cur_level` takes the most recently pushed level. If the stack is empty, it takes 3.
- R10: An acknowledge while the stack holds DEPTH (4) entries raises `stack_ovf` for exactly the following cycle. It still updates `cur_level` but pushes nothing.
- R11: `irq_req`, `irq_idx` and `irq_level` are combinational from the registered state and `gie`. A state change at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NSRC | Per-source event pulses |
| cfg_we | input | 1 | Write the enable and level of one source |
| cfg_idx | input | IW | Source addressed by the write |
| cfg_en | input | 1 | Enable value written |
| cfg_level | input | 2 | Level code written |
| clr_valid | input | 1 | Clear one pending flag |
| clr_idx | input | IW | Source whose flag is cleared |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | One-cycle acknowledge |
| ack_idx | input | IW | Source index accepted |
| ret_strobe | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request |
| irq_idx | output | IW | Winning source index |
| irq_level | output | 2 | Winning effective level |
| cur_level | output | 2 | Running interrupt level |
| stack_ovf | output | 1 | Overflow pulse on acknowledge with full stack |

## Verification
A corrupted pending flag, enable bit or level field changes the winner on `irq_idx`/`irq_level` or the value of `irq_req` at the first sample after the faulty edge. This happens as soon as that source is pending and competing. A wrong running level or a wrong stack entry shows on `cur_level` right after the acknowledge or return that uses it. It also shows indirectly as a request that is wrongly held back or let through. A miscounted stack depth appears as a missing or spurious `stack_ovf` pulse on the fifth nested acknowledge, or as a wrong level restored after the fourth return.

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IW = $clog2(NSRC),
  localparam int SW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_event,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic            cfg_en,
  input  logic [1:0]      cfg_level,
  input  logic            clr_valid,
  input  logic [IW-1:0]   clr_idx,
  input  logic            gie,
  input  logic            ack_valid,
  input  logic [IW-1:0]   ack_idx,
  input  logic            ret_strobe,
  output logic            irq_req,
  output logic [IW-1:0]   irq_idx,
  output logic [1:0]      irq_level,
  output logic [1:0]      cur_level,
  output logic            stack_ovf
);

  function automatic logic [1:0] eff(input logic [1:0] l);
    return (l == 2'd0) ? 2'd1 : l;
  endfunction

  logic [NSRC-1:0] pend, en;
  logic [1:0]      lvl [NSRC];
  logic [1:0]      stk [DEPTH];
  logic [SW-1:0]   sp;
  logic [NSRC-1:0] clr_mask;
  logic            found;
  logic [IW-1:0]   win_idx;
  logic [1:0]      win_lvl;

  assign clr_mask = clr_valid ? (NSRC'(1) << clr_idx) : '0;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = 2'd3;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && en[i] && eff(lvl[i]) != 2'd3 && eff(lvl[i]) <= win_lvl) begin
        found   = 1'b1;
        win_idx = IW'(i);
        win_lvl = eff(lvl[i]);
      end
    end
  end

  assign irq_req   = found && gie && (win_lvl < cur_level);
  assign irq_idx   = win_idx;
  assign irq_level = win_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= 2'd3;
    end else begin
      pend <= (pend & ~clr_mask) | src_event;
      if (cfg_we) begin
        en[cfg_idx]  <= cfg_en;
        lvl[cfg_idx] <= cfg_level;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_level <= 2'd3;
      sp        <= '0;
      stack_ovf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= 2'd3;
    end else begin
      stack_ovf <= 1'b0;
      if (ack_valid) begin
        cur_level <= eff(lvl[ack_idx]);
        if (sp == SW'(DEPTH)) begin
          stack_ovf <= 1'b1;
        end else begin
          stk[PW'(sp)] <= cur_level;
          sp           <= sp + 1'b1;
        end
      end else if (ret_strobe) begin
        if (sp != '0) begin
          cur_level <= stk[PW'(sp - 1'b1)];
          sp        <= sp - 1'b1;
        end else begin
          cur_level <= 2'd3;
        end
      end
    end
  end

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_chk #(parameter int IW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie,
  input logic          ack_valid,
  input logic [IW-1:0] ack_idx,
  input logic          irq_req,
  input logic [IW-1:0] irq_idx,
  input logic [1:0]    irq_level,
  input logic [1:0]    cur_level,
  input logic          stack_ovf
);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);

  p_urgency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level < cur_level));

  p_level_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level == 2'd1 || irq_level == 2'd2));

  p_ack_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && irq_req && ack_idx == irq_idx) |=> (cur_level == $past(irq_level)));

  p_cur_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level != 2'd0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |-> $past(ack_valid));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.IW(IW)) chk_i (.*);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  localparam int N = 8, D = 4, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] ev = '0;
  logic cfg_we = 0, cfg_en = 0, clr_v = 0, gie = 0, ack_v = 0, ret = 0;
  logic [IW-1:0] cfg_idx = '0, clr_idx = '0, ack_idx = '0;
  logic [1:0] cfg_lvl = '0;
  logic irq_req, stack_ovf;
  logic [IW-1:0] irq_idx;
  logic [1:0] irq_level, cur_level;

  lvl_irq_ctrl #(.NSRC(N), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_event(ev), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_level(cfg_lvl), .clr_valid(clr_v), .clr_idx(clr_idx),
    .gie(gie), .ack_valid(ack_v), .ack_idx(ack_idx), .ret_strobe(ret),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_level(irq_level),
    .cur_level(cur_level), .stack_ovf(stack_ovf));

  int checks = 0, failures = 0;

  logic [1:0]   m_lvl [N];
  logic [N-1:0] m_en, m_pend;
  logic [1:0]   m_cur;
  logic [1:0]   m_stk [D];
  int           m_sp;
  logic         m_ovf;
  logic         e_req;
  logic [IW-1:0] e_idx;
  logic [1:0]   e_lvl;

  function automatic logic [1:0] eff(input logic [1:0] l);
    return (l == 2'd0) ? 2'd1 : l;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic predict();
    logic [1:0] best;
    best = 2'd3; e_req = 0; e_idx = '0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && eff(m_lvl[i]) < best) begin
        best = eff(m_lvl[i]); e_idx = IW'(i);
      end
    e_lvl = best;
    e_req = (best != 2'd3) && gie && (best < m_cur);
  endtask

  task automatic model_edge();
    m_ovf = 0;
    if (ack_v) begin
      if (m_sp == D) m_ovf = 1;
      else begin m_stk[m_sp] = m_cur; m_sp++; end
      m_cur = eff(m_lvl[ack_idx]);
    end else if (ret) begin
      if (m_sp > 0) begin m_sp--; m_cur = m_stk[m_sp]; end
      else m_cur = 2'd3;
    end
    if (cfg_we) begin m_lvl[cfg_idx] = cfg_lvl; m_en[cfg_idx] = cfg_en; end
    m_pend = (m_pend & ~(clr_v ? (N'(1) << clr_idx) : N'(0))) | ev;
  endtask

  task automatic compare(input string tag);
    predict();
    chk(tag, "irq_req", int'(irq_req), int'(e_req));
    if (e_req) begin
      chk(tag, "irq_idx", int'(irq_idx), int'(e_idx));
      chk(tag, "irq_level", int'(irq_level), int'(e_lvl));
    end
    chk(tag, "cur_level", int'(cur_level), int'(m_cur));
    chk(tag, "stack_ovf", int'(stack_ovf), int'(m_ovf));
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    ev = '0; clr_v = 0; cfg_we = 0; ack_v = 0; ret = 0;
  endtask

  task automatic wr(input int idx, input logic e, input logic [1:0] l);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = e; cfg_lvl = l;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < N; i++) m_lvl[i] = 2'd3;
    m_en = '0; m_pend = '0; m_cur = 2'd3; m_sp = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    gie = 1;
    ev = '1; cyc("R1");
    cyc("R1");

    wr(2, 0, 2'd1); cyc("R3");
    wr(2, 1, 2'd1); cyc("R3");
    chk("R3", "irq_idx", int'(irq_idx), 2);

    gie = 0; cyc("R7");
    chk("R7", "irq_req", int'(irq_req), 0);
    gie = 1;

    wr(5, 1, 2'd1); cyc("R5");
    chk("R5", "irq_idx", int'(irq_idx), 2);
    wr(1, 1, 2'd2); cyc("R5");
    wr(1, 1, 2'd0); cyc("R4");
    chk("R4", "irq_level", int'(irq_level), 1);
    chk("R4", "irq_idx", int'(irq_idx), 1);
    wr(1, 1, 2'd3); cyc("R4");

    clr_v = 1; clr_idx = 3'd2; ev = 8'h04; cyc("R2");
    chk("R2", "irq_idx", int'(irq_idx), 2);
    clr_v = 1; clr_idx = 3'd2; cyc("R2");
    cyc("R2");
    chk("R2", "irq_idx", int'(irq_idx), 5);

    ack_v = 1; ack_idx = 3'd5; cyc("R8");
    chk("R6", "irq_req", int'(irq_req), 0);
    wr(5, 1, 2'd2); ack_v = 1; ack_idx = 3'd5; ret = 1; cyc("R8");
    ret = 1; cyc("R9");
    ret = 1; cyc("R9");
    chk("R9", "cur_level", int'(cur_level), 3);
    ret = 1; cyc("R9");

    wr(0, 1, 2'd1); cyc("R10");
    for (int k = 0; k < 5; k++) begin ack_v = 1; ack_idx = 3'd0; cyc("R10"); end
    chk("R10", "stack_ovf", int'(stack_ovf), 1);
    cyc("R10");
    for (int k = 0; k < 5; k++) begin ret = 1; cyc("R9"); end
    chk("R9", "cur_level", int'(cur_level), 3);

    for (int k = 0; k < 4000; k++) begin
      int r;
      predict();
      ev = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      clr_v = ($urandom_range(0, 2) == 0); clr_idx = IW'($urandom);
      if ($urandom_range(0, 3) == 0) wr(int'($urandom_range(0, N - 1)), 1'($urandom), 2'($urandom));
      r = $urandom_range(0, 9);
      if (r < 3 && e_req) begin ack_v = 1; ack_idx = e_idx; end
      else if (r == 3) begin ack_v = 1; ack_idx = IW'($urandom); end
      else if (r < 6) ret = 1;
      gie = ($urandom_range(0, 7) != 0);
      cyc("R11");
    end
    report();
  end
endmodule